// File: doc/BRIEF.md
# Serial Frame Receiver with Even-Parity and Break Classification

This block sits behind a boundary-scan data register and turns a stream of bits arriving on the test data input into bytes for a debug controller. Each frame is nine bits long: eight data bits, least significant first, and then one parity bit. The bits enter a shift register on every test clock rising edge while the shift strobe is high. When the update strobe arrives, a complete frame is moved in parallel to the output register and a one-cycle valid pulse is raised.

Every accepted frame is classified. If the nine bits hold an odd number of ones, parity has failed. A parity failure on the reserved code 0xBB is reported as a break, and the ordinary parity-error flag stays low. Any other parity failure raises the parity-error flag. A frame that ends before nine shift clocks is dropped. The test-logic-reset strobe clears the partial frame, the byte and the flags.

A small state machine (`jfr_ctrl`) tracks how much of the frame has arrived. It has three states. ST_IDLE means no bits since the last update or reset. ST_COLLECT means one to eight bits. ST_FULL means nine or more bits. Its transitions are:
- ST_IDLE to ST_COLLECT on a shift.
- ST_COLLECT to ST_FULL on the shift that brings in the ninth bit.
- ST_COLLECT stays in ST_COLLECT on earlier shifts.
- ST_FULL stays in ST_FULL on further shifts.
- Any state to ST_IDLE on update or on test-logic-reset.

Update has priority over shift in the same cycle, and test-logic-reset has priority over both.

Top module: `jtag_frame_rx`

## Requirements
- R1: Bits are shifted in least significant bit first. The k-th bit shifted in (k = 0..7) becomes bit k of `rx_data_o`, and the ninth bit is the parity bit.
- R2: If at least nine shift cycles have occurred since the last update, reset or test-logic-reset, an update strobe sampled on a rising edge causes two things after that edge: `rx_valid_o` is high for exactly one cycle, and `rx_data_o` carries the frame byte.
- R3: If more than nine bits are shifted before update, the last nine bits shifted form the frame.
- R4: An update with fewer than nine shifts since the previous update or reset gives no valid pulse. The byte and flags keep their previous values, and the partial frame is discarded.
- R5: Even parity. `par_err_o` is 1 for an accepted non-break frame whose nine bits contain an odd number of ones. It is 0 when that count is even.
- R6: An accepted frame with odd parity and data 0xBB sets `brk_o` to 1 and `par_err_o` to 0. `brk_o` and `par_err_o` are never high together.
- R7: Data 0xBB with parity bit 0, which gives even parity, is an ordinary good frame: `brk_o` = 0 and `par_err_o` = 0.
- R8: `rx_data_o`, `par_err_o` and `brk_o` hold their values until the next accepted frame or reset.
- R9: `tlr_i` sampled high clears `rx_data_o`, `rx_valid_o`, `par_err_o` and `brk_o` to 0 after that edge, and discards any partial frame.
- R10: After `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; everything acts on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tdi | input | 1 | Serial data in |
| shift_dr_i | input | 1 | Shift strobe: take one bit this cycle |
| update_dr_i | input | 1 | Update strobe: transfer the frame if complete |
| tlr_i | input | 1 | Test-logic-reset strobe |
| rx_data_o | output | 8 | Last accepted data byte |
| rx_valid_o | output | 1 | One-cycle pulse for an accepted frame |
| par_err_o | output | 1 | Parity failure on a non-break frame |
| brk_o | output | 1 | Break code received with bad parity |

## Verification
The bench targets the following boundaries and the failure each one would expose:
- Bit order is tested with 0x01 and 0x80. A receiver that shifts most significant bit first would swap these two bytes.
- An eight-bit frame is followed by update. A counter that is off by one would accept it and raise a valid pulse.
- A ten-bit frame is sent. A receiver that keeps the first nine bits instead of the last nine would return a shifted byte.
- 0xBB is sent with both parity values. A break detector not gated by the parity check would flag the good copy. A design that does not suppress the plain parity flag would raise both flags on the bad copy.
- Test-logic-reset is issued in the middle of a frame, followed by just enough bits to reach nine in total. If the partial frame were kept, this would produce a false valid pulse.

// File: rtl/jfr_pkg.sv
package jfr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_FULL    = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic perr;
        logic brk;
    } frame_status_t;

endpackage

// File: rtl/jfr_shifter.sv
module jfr_shifter #(
    parameter int FRAME_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               shift_en_i,
    input  logic               bit_i,
    output logic [FRAME_W-1:0] frame_o
);

    logic [FRAME_W-1:0] frame_q;
    logic [FRAME_W-1:0] frame_shifted;

    // new bit enters at the top; after FRAME_W shifts the first bit sits at 0
    genvar gi;
    generate
        for (gi = 0; gi < FRAME_W; gi++) begin : g_stage
            if (gi == FRAME_W - 1) begin : g_top
                assign frame_shifted[gi] = bit_i;
            end else begin : g_mid
                assign frame_shifted[gi] = frame_q[gi+1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (clear_i) begin
            frame_q <= '0;
        end else if (shift_en_i) begin
            frame_q <= frame_shifted;
        end
    end

    assign frame_o = frame_q;

endmodule

// File: rtl/jfr_classify.sv
module jfr_classify
    import jfr_pkg::*;
#(
    parameter int          DATA_W     = 8,
    parameter logic [DATA_W-1:0] BREAK_CODE = 8'hBB
) (
    input  logic [DATA_W:0]   frame_i,
    output logic [DATA_W-1:0] data_o,
    output frame_status_t     status_o
);

    logic odd_ones;
    logic is_break;

    always_comb begin
        data_o          = frame_i[DATA_W-1:0];
        odd_ones        = ^frame_i;
        is_break        = odd_ones && (frame_i[DATA_W-1:0] == BREAK_CODE);
        status_o.brk    = is_break;
        status_o.perr   = odd_ones && !is_break;
    end

endmodule

// File: rtl/jfr_ctrl.sv
module jfr_ctrl
    import jfr_pkg::*;
#(
    parameter int                DATA_W     = 8,
    parameter logic [DATA_W-1:0] BREAK_CODE = 8'hBB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_dr_i,
    input  logic              update_dr_i,
    input  logic              tlr_i,
    input  logic [DATA_W-1:0] data_i,
    input  frame_status_t     status_i,
    output logic              clear_o,
    output logic              shift_en_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              par_err_o,
    output logic              brk_o
);

    localparam int FRAME_W = DATA_W + 1;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_W - 1);

    rx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             take_bit;
    logic             accept;

    assign take_bit   = shift_dr_i && !update_dr_i && !tlr_i;
    assign accept     = update_dr_i && !tlr_i && (state_q == ST_FULL);
    assign shift_en_o = take_bit;
    assign clear_o    = tlr_i;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (tlr_i || update_dr_i) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else if (shift_dr_i) begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_d   = CNT_W'(1);
                    state_d = (FRAME_W == 1) ? ST_FULL : ST_COLLECT;
                end
                ST_COLLECT: begin
                    cnt_d   = cnt_q + CNT_W'(1);
                    state_d = (cnt_q == LAST_CNT) ? ST_FULL : ST_COLLECT;
                end
                ST_FULL: begin
                    state_d = ST_FULL;
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data_o  <= '0;
            rx_valid_o <= 1'b0;
            par_err_o  <= 1'b0;
            brk_o      <= 1'b0;
        end else if (tlr_i) begin
            rx_data_o  <= '0;
            rx_valid_o <= 1'b0;
            par_err_o  <= 1'b0;
            brk_o      <= 1'b0;
        end else begin
            rx_valid_o <= accept;
            if (accept) begin
                rx_data_o <= data_i;
                par_err_o <= status_i.perr;
                brk_o     <= status_i.brk;
            end
        end
    end

    a_r2_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    a_r2_valid_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (update_dr_i && !tlr_i && state_q == ST_FULL) |=> rx_valid_o);

    a_r4_short_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (update_dr_i && state_q != ST_FULL) |=> !rx_valid_o);

    a_r3_full_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL && shift_dr_i && !update_dr_i && !tlr_i) |=> state_q == ST_FULL);

    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(brk_o && par_err_o));

    a_r6_brk_code: assert property (@(posedge clk) disable iff (!rst_n)
        brk_o |-> rx_data_o == BREAK_CODE);

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(update_dr_i && state_q == ST_FULL) && !tlr_i)
        |=> ($stable(rx_data_o) && $stable(par_err_o) && $stable(brk_o)));

    a_r9_tlr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        tlr_i |=> (!rx_valid_o && !par_err_o && !brk_o && rx_data_o == '0));

endmodule

// File: rtl/jtag_frame_rx.sv
module jtag_frame_rx
    import jfr_pkg::*;
#(
    parameter int                DATA_W     = 8,
    parameter logic [DATA_W-1:0] BREAK_CODE = 8'hBB
) (
    input  logic              tck,
    input  logic              rst_n,
    input  logic              tdi,
    input  logic              shift_dr_i,
    input  logic              update_dr_i,
    input  logic              tlr_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              par_err_o,
    output logic              brk_o
);

    localparam int FRAME_W = DATA_W + 1;

    logic               clear;
    logic               shift_en;
    logic [FRAME_W-1:0] frame;
    logic [DATA_W-1:0]  frame_data;
    frame_status_t      frame_status;

    jfr_shifter #(.FRAME_W(FRAME_W)) u_shifter (
        .clk        (tck),
        .rst_n      (rst_n),
        .clear_i    (clear),
        .shift_en_i (shift_en),
        .bit_i      (tdi),
        .frame_o    (frame)
    );

    jfr_classify #(.DATA_W(DATA_W), .BREAK_CODE(BREAK_CODE)) u_classify (
        .frame_i  (frame),
        .data_o   (frame_data),
        .status_o (frame_status)
    );

    jfr_ctrl #(.DATA_W(DATA_W), .BREAK_CODE(BREAK_CODE)) u_ctrl (
        .clk         (tck),
        .rst_n       (rst_n),
        .shift_dr_i  (shift_dr_i),
        .update_dr_i (update_dr_i),
        .tlr_i       (tlr_i),
        .data_i      (frame_data),
        .status_i    (frame_status),
        .clear_o     (clear),
        .shift_en_o  (shift_en),
        .rx_data_o   (rx_data_o),
        .rx_valid_o  (rx_valid_o),
        .par_err_o   (par_err_o),
        .brk_o       (brk_o)
    );

endmodule

// File: tb/test_jtag_frame_rx.sv
`timescale 1ns/1ps
module test_jtag_frame_rx;

    logic       tck = 1'b0;
    logic       rst_n = 1'b0;
    logic       tdi = 1'b0;
    logic       shift_dr = 1'b0;
    logic       update_dr = 1'b0;
    logic       tlr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       par_err;
    logic       brk;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 tck = ~tck;

    jtag_frame_rx i_jtag_frame_rx (
        .tck         (tck),
        .rst_n       (rst_n),
        .tdi         (tdi),
        .shift_dr_i  (shift_dr),
        .update_dr_i (update_dr),
        .tlr_i       (tlr),
        .rx_data_o   (rx_data),
        .rx_valid_o  (rx_valid),
        .par_err_o   (par_err),
        .brk_o       (brk)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic shift_bit(input logic b);
        @(negedge tck);
        shift_dr = 1'b1;
        tdi      = b;
        @(negedge tck);
        shift_dr = 1'b0;
    endtask

    task automatic shift_bits(input logic [8:0] f, input int n);
        for (int i = 0; i < n; i++) shift_bit(f[i]);
    endtask

    // pulse update; returns at the negedge after the sampling edge
    task automatic do_update();
        @(negedge tck);
        update_dr = 1'b1;
        @(negedge tck);
        update_dr = 1'b0;
    endtask

    task automatic send_frame(input string req, input logic [7:0] d, input logic p,
                              input logic exp_perr, input logic exp_brk);
        shift_bits({p, d}, 9);
        do_update();
        chk({req, " valid"}, rx_valid, 1);
        chk({req, " data"}, rx_data, d);
        chk({req, " perr"}, par_err, exp_perr);
        chk({req, " brk"}, brk, exp_brk);
    endtask

    task automatic t_reset();
        chk("R10 data", rx_data, 0);
        chk("R10 valid", rx_valid, 0);
        chk("R10 perr", par_err, 0);
        chk("R10 brk", brk, 0);
    endtask

    task automatic t_good_and_hold();
        send_frame("R2 good 5A", 8'h5A, 1'b0, 1'b0, 1'b0);
        @(negedge tck);
        chk("R2 single pulse", rx_valid, 0);
        repeat (3) @(negedge tck);
        chk("R8 hold data", rx_data, 8'h5A);
    endtask

    task automatic t_parity();
        send_frame("R5 bad 5A", 8'h5A, 1'b1, 1'b1, 1'b0);
        repeat (2) @(negedge tck);
        chk("R8 hold perr", par_err, 1);
        send_frame("R5 good 01", 8'h01, 1'b1, 1'b0, 1'b0);
        send_frame("R1 order 80", 8'h80, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_break();
        send_frame("R6 break", 8'hBB, 1'b1, 1'b0, 1'b1);
        send_frame("R7 BB even", 8'hBB, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_short();
        shift_bits({1'b0, 8'h33}, 8);
        do_update();
        chk("R4 no valid", rx_valid, 0);
        chk("R4 data kept", rx_data, 8'hBB);
        send_frame("R4 recover", 8'h3C, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_long();
        shift_bit(1'b1);
        send_frame("R3 long C3", 8'hC3, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_tlr();
        send_frame("R9 setup brk", 8'hBB, 1'b1, 1'b0, 1'b1);
        shift_bits(9'h1FF, 5);
        @(negedge tck);
        tlr = 1'b1;
        @(negedge tck);
        tlr = 1'b0;
        chk("R9 data clr", rx_data, 0);
        chk("R9 brk clr", brk, 0);
        chk("R9 perr clr", par_err, 0);
        shift_bits(9'h1FF, 4);
        do_update();
        chk("R9 partial dropped", rx_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge tck);
        t_reset();
        rst_n = 1'b1;
        @(negedge tck);
        t_good_and_hold();
        t_parity();
        t_break();
        t_short();
        t_long();
        t_tlr();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule